// File: doc/BRIEF.md
# Endpoint Control and Interrupt-Enable Register Bank

This block holds the per-endpoint control and interrupt-enable word of a USB device controller. The word is replicated for nine endpoints. Software never writes the word itself. To change a bit, software writes a one to that bit position in a "set" alias or a "clear" alias of the endpoint, and it reads the resulting word back from the endpoint's own address. Bits written as zero in either alias leave the word unchanged.

Hardware events also act on some bits. A received SETUP packet withdraws a pending stall request. A bank becoming ready (an IN bank freed, or an OUT bank filled) raises the bank-handover bit. The end of a kill procedure drops the kill request. One bit never holds a value: writing it produces a one-cycle pulse that resets the data toggle. The status flags come from outside the block. The block gates each flag with its enable bit and drives one interrupt line per endpoint.

Top module: `ep_mask_bank`

## Requirements
- R1: Endpoint x (0..8) reads back its word at byte address 0x1C0+4x. Its set alias is at 0x200+4x and its clear alias is at 0x240+4x. The aliases and every unmapped address read as 0.
- R2: After reset every word reads 0. The bit positions 31:20, 15 and 11:8 always read 0, even after all ones are written to the set alias.
- R3: The interrupt enables (bits 7:0, and bit 12 for busy banks), the ACK-instead-of-NYET bit (17), the DMA-hold bit (16) and the stall request (19) become 1 on a set-alias write with a one at their position. They become 0 on a clear-alias write with a one at their position. Zero bits in the write data change nothing.
- R4: When software and hardware act on the same bit in the same cycle, the set side wins. A bank-ready event beats a software clear of bit 14. A software set of bit 19 beats a SETUP reception. A software set of bit 13 beats a kill-done event.
- R5: A SETUP reception clears the stall request (bit 19). `stall_req_o` mirrors bit 19.
- R6: A set-alias write with bit 18 at one raises `toggle_rst_o` for exactly the one cycle after the write. Bit 18 always reads 0.
- R7: On a non-control endpoint, `bank_ready` sets bit 14, and a set-alias write to bit 14 has no effect. A clear-alias write to bit 14 while it is 1 clears it and raises `bank_release_o` for the one cycle after the write.
- R8: On an endpoint marked as control, bit 14 reads 0. On such an endpoint, `bank_ready` and clear writes to bit 14 have no effect and produce no `bank_release_o`.
- R9: A set-alias write to bit 13 raises the kill request. `kill_done` clears it, and the clear alias does not. `kill_req_o` mirrors bit 13.
- R10: `ep_irq_o[x]` is the OR of the 9-bit flag group `ev_flags[9x+8:9x]` masked by its enables. Flags 0..7 pair with enable bits 0..7, and flag 8 pairs with bit 12. The interrupt line follows the flags and enables in the same cycle.
- R11: `nyet_off_o` and `dma_hold_o` mirror bits 17 and 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| ep_is_ctrl | input | 9 | Endpoint is of control type |
| setup_rx | input | 9 | SETUP packet received, per endpoint |
| bank_ready | input | 9 | Bank freed (IN) or filled (OUT), per endpoint |
| kill_done | input | 9 | Kill procedure finished, per endpoint |
| ev_flags | input | 81 | Status flags, 9 per endpoint |
| stall_req_o | output | 9 | Stall request per endpoint |
| toggle_rst_o | output | 9 | One-cycle data toggle reset pulse |
| nyet_off_o | output | 9 | Answer ACK instead of NYET |
| dma_hold_o | output | 9 | Pause DMA on endpoint interrupt |
| bank_release_o | output | 9 | One-cycle bank handover pulse |
| kill_req_o | output | 9 | Kill-last-bank request |
| ep_irq_o | output | 9 | Gated endpoint interrupt |

## Verification
The bench builds the block with its default parameters: nine endpoints, 12 address bits, and the three base addresses. With these values the top endpoint's word at 0x1E0 is reachable, as are the gaps between the three regions. Endpoint 0 is marked as control and the others are not. This lets the same stimulus show bank-ready taking effect on one endpoint and being ignored on another. The collision cases drive a hardware event and an alias write into the same clock edge to expose the priority order.

// File: rtl/ep_mask_pkg.sv
package ep_mask_pkg;

    localparam int WORD_W     = 32;
    localparam int IE_W       = 8;
    localparam int NFLAG      = IE_W + 1;

    localparam int B_STALL    = 19;
    localparam int B_TOGRST   = 18;
    localparam int B_NYETOFF  = 17;
    localparam int B_DMAHOLD  = 16;
    localparam int B_BANK     = 14;
    localparam int B_KILL     = 13;
    localparam int B_BUSYIE   = 12;

    localparam logic [WORD_W-1:0] SET_ACTIVE =
        (32'h1 << B_STALL) | (32'h1 << B_TOGRST) | (32'h1 << B_NYETOFF) |
        (32'h1 << B_DMAHOLD) | (32'h1 << B_KILL) | (32'h1 << B_BUSYIE) | 32'hFF;

    localparam logic [WORD_W-1:0] CLR_ACTIVE =
        (32'h1 << B_STALL) | (32'h1 << B_NYETOFF) | (32'h1 << B_DMAHOLD) |
        (32'h1 << B_BANK) | (32'h1 << B_BUSYIE) | 32'hFF;

    typedef struct packed {
        logic            stall;
        logic            nyet_off;
        logic            dma_hold;
        logic            bank;
        logic            kill;
        logic            busy_ie;
        logic [IE_W-1:0] ie;
    } ep_ctl_t;

    function automatic logic [WORD_W-1:0] ctl_view(ep_ctl_t c);
        logic [WORD_W-1:0] w;
        w              = '0;
        w[B_STALL]     = c.stall;
        w[B_NYETOFF]   = c.nyet_off;
        w[B_DMAHOLD]   = c.dma_hold;
        w[B_BANK]      = c.bank;
        w[B_KILL]      = c.kill;
        w[B_BUSYIE]    = c.busy_ie;
        w[IE_W-1:0]    = c.ie;
        return w;
    endfunction

    function automatic logic gate_irq(ep_ctl_t c, logic [NFLAG-1:0] f);
        return (|(f[IE_W-1:0] & c.ie)) | (f[IE_W] & c.busy_ie);
    endfunction

    function automatic logic upd(logic q, logic s, logic c);
        return s | (q & ~c);
    endfunction

endpackage

// File: rtl/ep_bus_decode.sv
module ep_bus_decode #(
    parameter int NUM_EP    = 9,
    parameter int ADDR_W    = 12,
    parameter int MASK_BASE = 'h1C0,
    parameter int SET_BASE  = 'h200,
    parameter int CLR_BASE  = 'h240
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output logic [NUM_EP-1:0] set_sel,
    output logic [NUM_EP-1:0] clr_sel,
    output logic [NUM_EP-1:0] rd_sel
);
    localparam int STRIDE = 4;

    for (genvar x = 0; x < NUM_EP; x++) begin : g_dec
        assign rd_sel[x]  = (addr == ADDR_W'(MASK_BASE + STRIDE * x));
        assign set_sel[x] = we && (addr == ADDR_W'(SET_BASE + STRIDE * x));
        assign clr_sel[x] = we && (addr == ADDR_W'(CLR_BASE + STRIDE * x));
    end

    always_comb begin
        assert ($onehot0(set_sel | clr_sel)) else $error("AST_ONE_ALIAS_HIT"); // R1
    end
endmodule

// File: rtl/ep_mask_reg.sv
module ep_mask_reg
    import ep_mask_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              is_ctrl,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              setup_rx,
    input  logic              bank_ready,
    input  logic              kill_done,
    input  logic [NFLAG-1:0]  flags,
    output logic [WORD_W-1:0] view,
    output logic              stall_o,
    output logic              tog_o,
    output logic              nyet_o,
    output logic              dmah_o,
    output logic              release_o,
    output logic              kill_o,
    output logic              irq_o
);
    ep_ctl_t           q, d;
    logic [WORD_W-1:0] sv, cv;
    logic              tog_q, rel_q, rel_d;

    assign sv = set_we ? (wdata & SET_ACTIVE) : '0;
    assign cv = clr_we ? (wdata & CLR_ACTIVE) : '0;

    always_comb begin
        d          = q;
        d.stall    = upd(q.stall, sv[B_STALL], cv[B_STALL] | setup_rx);
        d.nyet_off = upd(q.nyet_off, sv[B_NYETOFF], cv[B_NYETOFF]);
        d.dma_hold = upd(q.dma_hold, sv[B_DMAHOLD], cv[B_DMAHOLD]);
        d.busy_ie  = upd(q.busy_ie, sv[B_BUSYIE], cv[B_BUSYIE]);
        d.kill     = upd(q.kill, sv[B_KILL], kill_done);
        d.bank     = is_ctrl ? 1'b0 : upd(q.bank, bank_ready, cv[B_BANK]);
        for (int k = 0; k < IE_W; k++)
            d.ie[k] = upd(q.ie[k], sv[k], cv[k]);
        rel_d      = !is_ctrl && q.bank && cv[B_BANK] && !bank_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            tog_q <= 1'b0;
            rel_q <= 1'b0;
        end else begin
            q     <= d;
            tog_q <= sv[B_TOGRST];
            rel_q <= rel_d;
        end
    end

    assign view      = ctl_view(q);
    assign stall_o   = q.stall;
    assign tog_o     = tog_q;
    assign nyet_o    = q.nyet_off;
    assign dmah_o    = q.dma_hold;
    assign kill_o    = q.kill;
    assign release_o = rel_q;
    assign irq_o     = gate_irq(q, flags);

    AST_SETUP_DROPS_STALL: assert property (@(posedge clk) disable iff (rst)
        (setup_rx && !(set_we && wdata[B_STALL])) |=> !stall_o) else $error("stall"); // R5
    AST_SW_SET_BEATS_SETUP: assert property (@(posedge clk) disable iff (rst)
        (set_we && wdata[B_STALL]) |=> stall_o) else $error("stall set"); // R4
    AST_BANK_HW_WINS: assert property (@(posedge clk) disable iff (rst)
        (bank_ready && !is_ctrl) |=> (q.bank || $past(is_ctrl) != is_ctrl)) else $error("bank"); // R4
    AST_CTRL_NO_BANK: assert property (@(posedge clk) disable iff (rst)
        ($past(is_ctrl) && is_ctrl) |-> (!q.bank && !release_o)) else $error("ctrl bank"); // R8
    AST_KILL_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (kill_done && !(set_we && wdata[B_KILL])) |=> !kill_o) else $error("kill"); // R9
    AST_TOG_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (tog_o && !$past(set_we && wdata[B_TOGRST])) |-> 1'b0) else $error("tog"); // R6
    AST_IE_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (set_we && wdata[IE_W-1:0] != '0) |=> ((q.ie & $past(wdata[IE_W-1:0])) == $past(wdata[IE_W-1:0])))
        else $error("ie"); // R3
endmodule

// File: rtl/ep_read_mux.sv
module ep_read_mux #(
    parameter int NUM_EP = 9,
    parameter int WORD_W = 32
) (
    input  logic [NUM_EP*WORD_W-1:0] views,
    input  logic [NUM_EP-1:0]        rd_sel,
    output logic [WORD_W-1:0]        rdata
);
    logic [WORD_W-1:0] part [NUM_EP];

    for (genvar x = 0; x < NUM_EP; x++) begin : g_gate
        assign part[x] = rd_sel[x] ? views[x*WORD_W +: WORD_W] : '0;
    end

    always_comb begin
        rdata = '0;
        for (int x = 0; x < NUM_EP; x++)
            rdata = rdata | part[x];
    end
endmodule

// File: rtl/ep_mask_bank.sv
module ep_mask_bank
    import ep_mask_pkg::*;
#(
    parameter int NUM_EP    = 9,
    parameter int ADDR_W    = 12,
    parameter int MASK_BASE = 'h1C0,
    parameter int SET_BASE  = 'h200,
    parameter int CLR_BASE  = 'h240
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_we,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic [NUM_EP-1:0]       ep_is_ctrl,
    input  logic [NUM_EP-1:0]       setup_rx,
    input  logic [NUM_EP-1:0]       bank_ready,
    input  logic [NUM_EP-1:0]       kill_done,
    input  logic [NUM_EP*9-1:0]     ev_flags,
    output logic [NUM_EP-1:0]       stall_req_o,
    output logic [NUM_EP-1:0]       toggle_rst_o,
    output logic [NUM_EP-1:0]       nyet_off_o,
    output logic [NUM_EP-1:0]       dma_hold_o,
    output logic [NUM_EP-1:0]       bank_release_o,
    output logic [NUM_EP-1:0]       kill_req_o,
    output logic [NUM_EP-1:0]       ep_irq_o
);
    logic [NUM_EP-1:0]        set_sel, clr_sel, rd_sel;
    logic [NUM_EP*WORD_W-1:0] views;

    ep_bus_decode #(
        .NUM_EP(NUM_EP), .ADDR_W(ADDR_W),
        .MASK_BASE(MASK_BASE), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
    ) u_dec (
        .addr(bus_addr), .we(bus_we),
        .set_sel(set_sel), .clr_sel(clr_sel), .rd_sel(rd_sel)
    );

    for (genvar x = 0; x < NUM_EP; x++) begin : g_ep
        ep_mask_reg u_reg (
            .clk(clk), .rst(rst),
            .is_ctrl(ep_is_ctrl[x]),
            .set_we(set_sel[x]), .clr_we(clr_sel[x]),
            .wdata(bus_wdata),
            .setup_rx(setup_rx[x]), .bank_ready(bank_ready[x]), .kill_done(kill_done[x]),
            .flags(ev_flags[x*NFLAG +: NFLAG]),
            .view(views[x*WORD_W +: WORD_W]),
            .stall_o(stall_req_o[x]), .tog_o(toggle_rst_o[x]),
            .nyet_o(nyet_off_o[x]), .dmah_o(dma_hold_o[x]),
            .release_o(bank_release_o[x]), .kill_o(kill_req_o[x]),
            .irq_o(ep_irq_o[x])
        );
    end

    ep_read_mux #(.NUM_EP(NUM_EP), .WORD_W(WORD_W)) u_mux (
        .views(views), .rd_sel(rd_sel), .rdata(bus_rdata)
    );

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata & 32'hFFF0_8F00) == '0) else $error("reserved"); // R2
endmodule

// File: tb/ep_mask_bank_test.sv
`timescale 1ns/1ps
module ep_mask_bank_test;
    localparam int N = 9;

    logic        clk = 0, rst = 1;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] ep_is_ctrl = 9'b000000001;
    logic [N-1:0] setup_rx = '0, bank_ready = '0, kill_done = '0;
    logic [N*9-1:0] ev_flags = '0;
    logic [N-1:0] stall_req_o, toggle_rst_o, nyet_off_o, dma_hold_o;
    logic [N-1:0] bank_release_o, kill_req_o, ep_irq_o;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ep_mask_bank uut (.*);

    function automatic logic [11:0] a_mask(int x); return 12'(12'h1C0 + 4*x); endfunction
    function automatic logic [11:0] a_set(int x);  return 12'(12'h200 + 4*x); endfunction
    function automatic logic [11:0] a_clr(int x);  return 12'(12'h240 + 4*x); endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        @(negedge clk);
        bus_we = 0; bus_wdata = '0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int x = 0; x < N; x++) begin
            rd(a_mask(x), v);
            chk("R2 reset word", v, 32'h0);
        end
        chk("R2 reset outputs", {stall_req_o, kill_req_o, ep_irq_o}, '0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(a_set(8), 32'h0000_0021);
        rd(a_mask(8), v); chk("R1 ep8 word", v, 32'h21);
        rd(a_mask(7), v); chk("R1 ep7 untouched", v, 32'h0);
        rd(a_set(8), v);  chk("R1 set alias reads 0", v, 32'h0);
        rd(a_clr(8), v);  chk("R1 clear alias reads 0", v, 32'h0);
        rd(12'h1E4, v);   chk("R1 unmapped reads 0", v, 32'h0);
        wr(a_clr(8), 32'h0000_0001);
        rd(a_mask(8), v); chk("R1 clear via alias", v, 32'h20);
        wr(a_clr(8), 32'h0000_0020);
    endtask

    task automatic t_set_clear();
        logic [31:0] v;
        wr(a_set(4), 32'hFFFF_FFFF);
        rd(a_mask(4), v);
        chk("R2 reserved read 0 / R3 all set", v, 32'h000B_30FF);
        chk("R11 nyet/dma outputs", {30'h0, nyet_off_o[4], dma_hold_o[4]}, 32'h3);
        wr(a_set(4), 32'h0);
        rd(a_mask(4), v); chk("R3 zero write no effect", v, 32'h000B_30FF);
        wr(a_clr(4), 32'h0003_1055);
        rd(a_mask(4), v); chk("R3 selective clear", v, 32'h0008_20AA);
        chk("R11 outputs after clear", {30'h0, nyet_off_o[4], dma_hold_o[4]}, 32'h0);
        wr(a_clr(4), 32'h0008_00AA);
        rd(a_mask(4), v); chk("R9 clear alias leaves kill", v, 32'h0000_2000);
        @(negedge clk); kill_done[4] = 1; @(negedge clk); kill_done[4] = 0;
        rd(a_mask(4), v); chk("R9 kill_done clears", v, 32'h0);
    endtask

    task automatic t_stall();
        logic [31:0] v;
        wr(a_set(1), 32'h0008_0000);
        chk("R5 stall out", {31'h0, stall_req_o[1]}, 32'h1);
        @(negedge clk); setup_rx[1] = 1; @(negedge clk); setup_rx[1] = 0;
        rd(a_mask(1), v); chk("R5 setup clears stall", v, 32'h0);
        @(negedge clk);
        bus_addr = a_set(1); bus_we = 1; bus_wdata = 32'h0008_0000; setup_rx[1] = 1;
        @(negedge clk);
        bus_we = 0; setup_rx[1] = 0;
        chk("R4 sw set beats setup", {31'h0, stall_req_o[1]}, 32'h1);
        wr(a_clr(1), 32'h0008_0000);
        chk("R3 stall cleared by alias", {31'h0, stall_req_o[1]}, 32'h0);
    endtask

    task automatic t_toggle();
        logic [31:0] v;
        wr(a_set(3), 32'h0004_0000);
        chk("R6 pulse high", {31'h0, toggle_rst_o[3]}, 32'h1);
        rd(a_mask(3), v); chk("R6 reads 0", v, 32'h0);
        @(negedge clk);
        chk("R6 pulse one cycle", {31'h0, toggle_rst_o[3]}, 32'h0);
    endtask

    task automatic t_bank();
        logic [31:0] v;
        wr(a_set(2), 32'h0000_4000);
        rd(a_mask(2), v); chk("R7 sw set of bank ignored", v, 32'h0);
        @(negedge clk); bank_ready[2] = 1; @(negedge clk); bank_ready[2] = 0;
        rd(a_mask(2), v); chk("R7 bank_ready sets", v, 32'h4000);
        @(negedge clk);
        bus_addr = a_clr(2); bus_we = 1; bus_wdata = 32'h4000; bank_ready[2] = 1;
        @(negedge clk);
        bus_we = 0; bank_ready[2] = 0;
        chk("R4 no release on collision", {31'h0, bank_release_o[2]}, 32'h0);
        rd(a_mask(2), v); chk("R4 hw set beats clear", v, 32'h4000);
        wr(a_clr(2), 32'h0000_4000);
        chk("R7 release pulse", {31'h0, bank_release_o[2]}, 32'h1);
        rd(a_mask(2), v); chk("R7 cleared", v, 32'h0);
        @(negedge clk);
        chk("R7 release one cycle", {31'h0, bank_release_o[2]}, 32'h0);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        @(negedge clk); bank_ready[0] = 1; @(negedge clk); bank_ready[0] = 0;
        rd(a_mask(0), v); chk("R8 ctrl bank reads 0", v, 32'h0);
        wr(a_clr(0), 32'h0000_4000);
        chk("R8 ctrl no release", {31'h0, bank_release_o[0]}, 32'h0);
    endtask

    task automatic t_kill();
        logic [31:0] v;
        @(negedge clk);
        bus_addr = a_set(6); bus_we = 1; bus_wdata = 32'h2000; kill_done[6] = 1;
        @(negedge clk);
        bus_we = 0; kill_done[6] = 0;
        chk("R4 kill set beats done", {31'h0, kill_req_o[6]}, 32'h1);
        @(negedge clk); kill_done[6] = 1; @(negedge clk); kill_done[6] = 0;
        rd(a_mask(6), v); chk("R9 kill cleared by done", v, 32'h0);
    endtask

    task automatic t_irq();
        wr(a_set(5), 32'h0000_0002);
        ev_flags[5*9 + 0] = 1; #0.5;
        chk("R10 unmasked flag no irq", {31'h0, ep_irq_o[5]}, 32'h0);
        ev_flags[5*9 + 1] = 1; #0.5;
        chk("R10 enabled flag irq", {31'h0, ep_irq_o[5]}, 32'h1);
        ev_flags = '0; ev_flags[5*9 + 8] = 1; #0.5;
        chk("R10 busy flag masked", {31'h0, ep_irq_o[5]}, 32'h0);
        wr(a_set(5), 32'h0000_1000); #0.5;
        chk("R10 busy flag enabled", {31'h0, ep_irq_o[5]}, 32'h1);
        chk("R10 other ep quiet", {23'h0, ep_irq_o & ~9'h020}, 32'h0);
        ev_flags = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_map();
        t_set_clear();
        t_stall();
        t_toggle();
        t_bank();
        t_ctrl();
        t_kill();
        t_irq();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
        $finish;
    end
endmodule